// File: doc/BRIEF.md
# Delay-Line Arrival-Time Encoder

This block turns a captured snapshot of a 50-tap delay line into a 6-bit arrival-time code. The delay line spans one 25 ns clock period in steps of roughly 0.5 ns. A threshold discriminator launches an edge down the line, and the tap states are latched on the clock edge that follows. The block finds where that edge sits in the line, reports the tap index in binary, and gives separate codes for a window with no hit and for an edge it cannot place.

Taps behind the edge read 1, so a clean pattern is a run of ones that starts at the edge position and runs up to the top tap. A single stray 1 can appear ahead of the real edge. Such a bubble is ignored, because a position counts only when the next tap is also set.

When the delay-locked loop reports that it is out of lock, the measurement cannot be trusted and the block reports overflow. The code is registered, and it is valid one clock after the snapshot strobe.

Top module: `tdc_therm_encoder`

## Requirements
- R1: While reset is asserted, and after it is released, `code_o` reads 62 and `code_vld_o` reads 0 until the first snapshot.
- R2: `code_vld_o` is high in exactly the cycle that follows a cycle with `snap_vld_i` high.
- R3: With lock high, the code is the lowest index i (0..48) for which `tap_i[i]` and `tap_i[i+1]` are both 1. Bit 0 is the earliest tap.
- R4: A lone 1 at index i < 49 whose upper neighbour `tap_i[i+1]` is 0 is a bubble. It never becomes the code, even when a valid edge lies at a higher index.
- R5: Tap 49 has no upper neighbour. When no lower position qualifies and `tap_i[49]` is 1, the code is 49.
- R6: With lock high and all taps 0, the code is 62, meaning no hit.
- R7: With lock high, taps not all 0, and no position qualifying, the code is 63, meaning overflow.
- R8: With `lock_i` low at the snapshot, the code is 63 whatever the taps hold.
- R9: While `snap_vld_i` is low, `code_o` keeps its value, and codes 50 through 61 never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tap_i | input | 50 | Latched delay-line taps, bit 0 earliest |
| snap_vld_i | input | 1 | Taps hold a fresh snapshot this cycle |
| lock_i | input | 1 | Delay-locked loop is in lock |
| code_o | output | 6 | Arrival index, 62 for no hit, 63 for overflow |
| code_vld_o | output | 1 | `code_o` was updated on the last edge |

## Verification
The design has a single register stage, so every code and its valid flag are due on the clock edge right after the strobe edge. The bench drives the taps and the strobe at a falling edge and drops the strobe at the next falling edge. It then samples both outputs at that same falling edge, half a period after they were registered. To check that the output holds, the bench changes the taps with the strobe low and samples again one cycle later.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int unsigned N_TAPS  = 50;
  localparam int unsigned CODE_W  = $clog2(N_TAPS);
  localparam logic [CODE_W-1:0] CODE_NOHIT = CODE_W'((1 << CODE_W) - 2);
  localparam logic [CODE_W-1:0] CODE_OVF   = CODE_W'((1 << CODE_W) - 1);
endpackage

// File: rtl/tdc_rst_sync.sv
module tdc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/tdc_pair_qual.sv
module tdc_pair_qual #(
  parameter int unsigned N = 50
) (
  input  logic [N-1:0] tap_i,
  output logic [N-1:0] qual_o
);
  // A position qualifies only when it and its upper neighbour are set.
  for (genvar g = 0; g < N - 1; g++) begin : g_pair
    assign qual_o[g] = tap_i[g] & tap_i[g+1];
  end
  // The top tap has no neighbour and stands on its own.
  assign qual_o[N-1] = tap_i[N-1];
endmodule

// File: rtl/tdc_first_set.sv
module tdc_first_set #(
  parameter int unsigned N = 50,
  parameter int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o,
  output logic         found_o
);
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o   = W'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdc_therm_encoder.sv
module tdc_therm_encoder
  import tdc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TAPS-1:0] tap_i,
  input  logic              snap_vld_i,
  input  logic              lock_i,
  output logic [CODE_W-1:0] code_o,
  output logic              code_vld_o
);
  logic              rst_n;
  logic [N_TAPS-1:0] qual;
  logic [CODE_W-1:0] first_idx;
  logic              first_found;
  logic [CODE_W-1:0] code_d, code_q;
  logic              vld_d, vld_q;

  tdc_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  tdc_pair_qual #(.N(N_TAPS)) u_qual (
    .tap_i  (tap_i),
    .qual_o (qual)
  );

  tdc_first_set #(.N(N_TAPS), .W(CODE_W)) u_first (
    .vec_i   (qual),
    .idx_o   (first_idx),
    .found_o (first_found)
  );

  // Next-state selection
  always_comb begin
    vld_d  = snap_vld_i;
    code_d = code_q;
    if (snap_vld_i) begin
      if (!lock_i)          code_d = CODE_OVF;
      else if (first_found) code_d = first_idx;
      else if (tap_i == '0) code_d = CODE_NOHIT;
      else                  code_d = CODE_OVF;
    end
  end

  // Register stage
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_NOHIT;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (snap_vld_i) code_q <= code_d;
    end
  end

  assign code_o     = code_q;
  assign code_vld_o = vld_q;

  assert_vld_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    snap_vld_i |=> code_vld_o);
  assert_vld_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !snap_vld_i |=> !code_vld_o);
  assert_unlock_ovf_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (snap_vld_i && !lock_i) |=> (code_o == CODE_OVF));
  assert_empty_nohit_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (snap_vld_i && lock_i && tap_i == '0) |=> (code_o == CODE_NOHIT));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !snap_vld_i |=> $stable(code_o));
  assert_no_gap_code_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (code_o < CODE_W'(N_TAPS)) || (code_o >= CODE_NOHIT));
  assert_edge_pos_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (snap_vld_i && lock_i && tap_i[0] && tap_i[1]) |=> (code_o == '0));
endmodule

// File: tb/tdc_therm_encoder_tb_top.sv
module tdc_therm_encoder_tb_top;
  localparam int NT = 50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] taps = '0;
  logic          snap = 1'b0;
  logic          lock = 1'b1;
  logic [5:0]    code;
  logic          vld;
  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tdc_therm_encoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tap_i(taps), .snap_vld_i(snap),
    .lock_i(lock), .code_o(code), .code_vld_o(vld)
  );

  function automatic int expect_code(logic [NT-1:0] t, logic lk);
    if (!lk) return 63;
    for (int i = 0; i < NT; i++)
      if (t[i] && (i == NT - 1 || t[i+1])) return i;
    if (t == '0) return 62;
    return 63;
  endfunction

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic [NT-1:0] t, logic lk);
    @(negedge clk);
    taps = t; lock = lk; snap = 1'b1;
    @(negedge clk);
    snap = 1'b0;
    check({req, " valid (R2)"}, int'(vld), 1);
    check(req, int'(code), expect_code(t, lk));
    if (code >= 50 && code < 62) check("R9 gap code", int'(code), 62);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [NT-1:0] t;
    repeat (3) @(negedge clk);
    check("R1 reset code", int'(code), 62);
    check("R1 reset valid", int'(vld), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 post-reset code", int'(code), 62);
    check("R1 post-reset valid", int'(vld), 0);

    // R3/R5: clean edge at every position
    for (int i = 0; i < NT; i++) begin
      t = '1; t = t << i;
      apply(i == NT - 1 ? "R5 top tap" : "R3 clean edge", t, 1'b1);
    end
    // R4: bubble below a real edge
    for (int i = 2; i < NT; i++) begin
      t = '1; t = t << i; t[i-2] = 1'b1;
      apply("R4 bubble ignored", t, 1'b1);
    end
    // R7 / R5: a single lone one at each position
    for (int i = 0; i < NT; i++) begin
      t = '0; t[i] = 1'b1;
      apply(i == NT - 1 ? "R5 lone top" : "R7 lone bubble", t, 1'b1);
    end
    apply("R6 empty", '0, 1'b1);
    apply("R7 alternating", {25{2'b01}}, 1'b1);
    apply("R3 dense pattern", {25{2'b11}}, 1'b1);
    // R8: unlocked
    apply("R8 unlock empty", '0, 1'b0);
    apply("R8 unlock edge", {{40{1'b1}}, 10'b0}, 1'b0);
    apply("R8 unlock full", '1, 1'b0);

    // R9: hold with no strobe
    apply("R3 edge before hold", {{30{1'b1}}, 20'b0}, 1'b1);
    @(negedge clk);
    taps = '0; lock = 1'b0;
    @(negedge clk);
    check("R9 hold code", int'(code), 20);
    check("R2 no strobe valid", int'(vld), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule